// File: doc/BRIEF.md
# Time-Stamp Line Serializer

This block drains 64-bit time-stamp records from a show-ahead FIFO and prints each one as a fixed 16-character text line on an asynchronous serial output. A line holds the seven-digit decimal time stamp, then the 32-bit input-event mask as eight hexadecimal characters, then a carriage return. The serial transmitter is built in. It uses 8N1 framing. Its bit period comes from a clock-enable divider that is set by the system clock frequency and the baud rate (defaults: 10 MHz and 9600 baud).

The time-stamp digits arrive already in BCD, so each decimal character is formed by placing a constant upper nibble above the digit. No binary-to-decimal arithmetic is involved. At 9600 baud the output link has close to twice the 32 lines per second that bursty sources need at peak. The FIFO in front of the block absorbs the bursts.

Top module: `stamp_line_tx`

## Requirements
- R1: Out of reset, and for as long as the FIFO reports empty, `txd_o` stays high and `fifo_rd_o` stays low.
- R2: `fifo_rd_o` is a one-cycle pulse that is raised only while `fifo_empty_i` is low and the block is idle. The record is taken from `fifo_data_i` in that same cycle, so later changes to the FIFO word have no effect on the line.
- R3: Each character is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. Between frames the line is high.
- R4: Every bit lasts round(CLK_HZ/BAUD) clock cycles. That is 1042 cycles with the default parameters.
- R5: A line is exactly 16 characters. Characters 0 to 6 come from the digit field `rec[59:32]`, most significant nibble `rec[59:56]` first. Characters 7 to 14 come from the mask `rec[31:0]`, nibble `rec[31:28]` first. Character 15 is 0x0D.
- R6: A time-stamp character is 0x30 with the digit nibble in its low four bits. There is no range check, so nibble 0xC gives 0x3C.
- R7: A mask nibble becomes 0x30 to 0x39 for values 0 to 9, and 0x41 to 0x46 for values A to F.
- R8: The next record is popped only after the stop bit of the previous line's carriage return has been fully sent.
- R9: Bits `rec[63:60]` have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | FIFO holds no record |
| fifo_data_i | input | 64 | Head record of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop strobe; the record is taken in the same cycle |
| txd_o | output | 1 | Serial output, idles high |

## Verification
The bound checker watches, on every cycle, the handshake and framing rules that can be seen at the ports and at the transmitter's busy and tick signals. A pop never happens while the FIFO is empty or while a frame is going out, the pop strobe never lasts longer than one cycle, the line is high whenever no frame is active, each frame opens with a low start bit, and the line level changes only on a bit tick. The content of each line can only be shown by the bench scenarios, which decode the serial stream and compare it against lines built from the requirements. The same holds for the character order, the treatment of non-decimal digit nibbles, the ignored top nibble, the exact bit width in cycles and the point at which the next pop happens.

// File: rtl/stamp_line_pkg.sv
package stamp_line_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DRAIN} fmt_state_e;

  localparam logic [7:0] DEC_HI   = 8'h30;
  localparam logic [7:0] ASCII_CR = 8'h0D;

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/stl_baud_gen.sv
module stl_baud_gen #(
  parameter int CPB = 1042
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (CPB > 1) ? $clog2(CPB) : 1;
  localparam logic [CW-1:0] LAST = CW'(CPB - 1);

  logic [CW-1:0] cnt_q;

  // counter held at zero while idle so every frame starts on a full bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/stl_uart_tx.sv
module stl_uart_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       txd_o
);
  logic [9:0] sh_q;
  logic [3:0] left_q;
  logic       busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        sh_q   <= {1'b1, byte_i, 1'b0};
        left_q <= 4'd10;
        busy_q <= 1'b1;
      end
    end else if (tick_i) begin
      sh_q   <= {1'b1, sh_q[9:1]};
      left_q <= left_q - 1'b1;
      if (left_q == 4'd1) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/stl_char_sel.sv
module stl_char_sel
  import stamp_line_pkg::*;
#(
  parameter int TS_DIGITS = 7,
  parameter int MASK_W    = 32,
  parameter int IDX_W     = 4,
  parameter int USED_W    = 4 * TS_DIGITS + MASK_W,
  parameter int LINE_LEN  = TS_DIGITS + MASK_W / 4 + 1
) (
  input  logic [USED_W-1:0] rec_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [7:0]        char_o
);
  localparam int HEX_N = MASK_W / 4;

  logic [7:0] chars [LINE_LEN];

  for (genvar g = 0; g < TS_DIGITS; g++) begin : g_dec
    assign chars[g] = DEC_HI | {4'h0, rec_i[MASK_W + 4*(TS_DIGITS-1-g) +: 4]};
  end

  for (genvar h = 0; h < HEX_N; h++) begin : g_hex
    assign chars[TS_DIGITS + h] = hex_char(rec_i[4*(HEX_N-1-h) +: 4]);
  end

  assign chars[LINE_LEN-1] = ASCII_CR;
  assign char_o = chars[idx_i];
endmodule

// File: rtl/stamp_line_tx.sv
module stamp_line_tx
  import stamp_line_pkg::*;
#(
  parameter int CLK_HZ    = 10_000_000,
  parameter int BAUD      = 9600,
  parameter int TS_DIGITS = 7,
  parameter int MASK_W    = 32,
  parameter int REC_W     = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_empty_i,
  input  logic [REC_W-1:0] fifo_data_i,
  output logic             fifo_rd_o,
  output logic             txd_o
);
  localparam int CPB      = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int LINE_LEN = TS_DIGITS + MASK_W / 4 + 1;
  localparam int IDX_W    = $clog2(LINE_LEN);
  localparam int USED_W   = 4 * TS_DIGITS + MASK_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_LEN - 1);

  fmt_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [USED_W-1:0] rec_q;
  logic              tx_busy, bit_tick, st_idle, load;
  logic [7:0]        cur_char;

  if (REC_W > USED_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^fifo_data_i[REC_W-1:USED_W];
  end

  assign st_idle   = (state_q == ST_IDLE);
  assign fifo_rd_o = st_idle && !fifo_empty_i;
  assign load      = (state_q == ST_SEND) && !tx_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rec_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (fifo_rd_o) begin
          rec_q   <= fifo_data_i[USED_W-1:0];
          idx_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: if (load) begin
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_DRAIN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        // wait for the carriage return stop bit before the next pop
        ST_DRAIN: if (!tx_busy) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  stl_char_sel #(
    .TS_DIGITS(TS_DIGITS),
    .MASK_W   (MASK_W),
    .IDX_W    (IDX_W),
    .USED_W   (USED_W),
    .LINE_LEN (LINE_LEN)
  ) u_char (
    .rec_i (rec_q),
    .idx_i (idx_q),
    .char_o(cur_char)
  );

  stl_baud_gen #(.CPB(CPB)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (tx_busy),
    .tick_o(bit_tick)
  );

  stl_uart_tx u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(bit_tick),
    .load_i(load),
    .byte_i(cur_char),
    .busy_o(tx_busy),
    .txd_o (txd_o)
  );
endmodule

// File: rtl/stamp_line_tx_chk.sv
module stamp_line_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fifo_empty_i,
  input logic fifo_rd_o,
  input logic txd_o,
  input logic tx_busy,
  input logic bit_tick,
  input logic st_idle
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i); // R2

  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !fifo_rd_o); // R2

  AST_NO_POP_MID_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (st_idle && !tx_busy)); // R8

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o); // R1

  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> !txd_o); // R3

  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy && $past(tx_busy) && !$past(bit_tick)) |-> $stable(txd_o)); // R4
endmodule

bind stamp_line_tx stamp_line_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_empty_i(fifo_empty_i),
  .fifo_rd_o   (fifo_rd_o),
  .txd_o       (txd_o),
  .tx_busy     (tx_busy),
  .bit_tick    (bit_tick),
  .st_idle     (st_idle)
);

// File: tb/stamp_line_tx_test.sv
`timescale 1ns/1ps
module stamp_line_tx_test;
  localparam int PER    = 8;
  localparam int CPB    = 8;
  localparam int BIT_NS = CPB * PER;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_empty;
  logic [63:0] fifo_data;
  logic        fifo_rd;
  logic        txd;

  logic [63:0] fq [8];
  int wr_p = 0;
  int rd_p = 0;
  int pop_cnt = 0;
  int falls = 0;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(PER/2) clk = ~clk;

  assign fifo_empty = (wr_p == rd_p);
  assign fifo_data  = fq[rd_p % 8];

  stamp_line_tx #(.CLK_HZ(80), .BAUD(10)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fifo_empty_i(fifo_empty),
    .fifo_data_i (fifo_data),
    .fifo_rd_o   (fifo_rd),
    .txd_o       (txd)
  );

  always @(posedge clk) begin
    if (fifo_rd) begin
      rd_p    <= rd_p + 1;
      pop_cnt <= pop_cnt + 1;
    end
  end

  always @(negedge txd) if (rst_n) falls <= falls + 1;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] v);
    @(negedge clk);
    fq[wr_p % 8] = v;
    wr_p++;
  endtask

  function automatic logic [7:0] want(input logic [63:0] r, input int k);
    logic [3:0] n;
    if (k < 7) return {4'h3, r[59 - 4*k -: 4]};
    if (k < 15) begin
      n = r[31 - 4*(k-7) -: 4];
      return (n <= 4'd9) ? 8'd48 + 8'(n) : 8'd65 + 8'(n) - 8'd10;
    end
    return 8'h0D;
  endfunction

  task automatic recv_byte(output logic [7:0] b, output bit fr_ok);
    logic st, sp;
    @(negedge txd);
    #(BIT_NS/2 + PER/2);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      #(BIT_NS);
      b[i] = txd;
    end
    #(BIT_NS);
    sp = txd;
    fr_ok = (st == 1'b0) && (sp == 1'b1);
  endtask

  task automatic recv_line(input logic [63:0] r, input string req);
    logic [7:0] b;
    bit fr;
    int errs = 0;
    for (int k = 0; k < 16; k++) begin
      recv_byte(b, fr);
      chk(fr, "R3 framing", {63'd0, fr}, 64'd1);
      if (b !== want(r, k)) begin
        errs++;
        chk(1'b0, req, 64'(b), 64'(want(r, k)));
      end
    end
    chk(errs == 0, req, 64'(errs), 64'd0);
  endtask

  task automatic t_reset_idle();
    chk(txd === 1'b1, "R1 txd after reset", 64'(txd), 64'd1);
    chk(fifo_rd === 1'b0, "R1 rd after reset", 64'(fifo_rd), 64'd0);
    repeat (40) @(negedge clk);
    chk(pop_cnt == 0, "R1 no pop while empty", 64'(pop_cnt), 64'd0);
    chk(falls == 0, "R1 line quiet while empty", 64'(falls), 64'd0);
  endtask

  task automatic t_bit_period();
    time t0, t1;
    push(64'h0_1000000_00000000); // first char 0x31, LSB 1
    @(negedge txd); t0 = $time;
    @(posedge txd); t1 = $time;
    chk((t1 - t0) == BIT_NS, "R4 start bit width", 64'(t1 - t0), 64'(BIT_NS));
    chk(pop_cnt == 1, "R2 single pop", 64'(pop_cnt), 64'd1);
    #(16 * 11 * BIT_NS);
  endtask

  task automatic t_line(input logic [63:0] r, input string req);
    push(r);
    recv_line(r, req);
  endtask

  task automatic t_capture();
    int base = pop_cnt;
    push(64'h0_7654321_0A1B2C3D);
    wait (pop_cnt == base + 1);
    @(negedge clk);
    fq[(wr_p - 1) % 8] = 64'h0_0000000_FFFFFFFF;
    recv_line(64'h0_7654321_0A1B2C3D, "R2 record taken at pop");
  endtask

  task automatic t_back_to_back();
    int base = pop_cnt;
    push(64'h0_2468024_13579BDF);
    push(64'h0_1357913_02468ACE);
    recv_line(64'h0_2468024_13579BDF, "R5 first of pair");
    chk(pop_cnt == base + 1, "R8 no pop before CR stop ends", 64'(pop_cnt), 64'(base + 1));
    recv_line(64'h0_1357913_02468ACE, "R5 second of pair");
    chk(pop_cnt == base + 2, "R8 second pop", 64'(pop_cnt), 64'(base + 2));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_bit_period();
    t_line(64'h0_1234567_89ABCDEF, "R5 R7 line content");
    t_line(64'hF_9876543_00000000, "R9 top nibble ignored");
    t_line(64'h0_0C0F0A0_FEDCBA98, "R6 raw nibble under 0x3");
    t_capture();
    t_back_to_back();
    repeat (20) @(negedge clk);
    chk(txd === 1'b1, "R1 idle after drain", 64'(txd), 64'd1);
    summary();
  end
endmodule